// File: doc/BRIEF.md
# Power Product and Averaging Engine

This block sits between a pair of measurement converters and the energy and alert logic of a rail monitor. Each time the upstream path presents a new sample, it takes a signed current code and an unsigned bus-voltage code together on one valid strobe. It multiplies the magnitude of the current by the voltage in fixed point and moves the product to the chosen power resolution with a programmable right shift. The result is clamped to the 16-bit register range, so a product that is too large reads as full scale and does not wrap. The block publishes this result as the instantaneous power register, together with a direction flag and a one-cycle ready pulse.

The same samples also feed a block-average filter with a selectable window of 1, 4, 16 or 64 samples. When a window closes, the averaged register updates and a one-cycle pulse marks the new value. Downstream logic can use either readout. Any configuration write loads a new shift and window depth. The same write clears both registers, the direction flag and the partially filled window, and it drops any sample still in the pipeline.

Top module: `pwr_avg_engine`

## Requirements
- R1: After a synchronous active-low reset, `inst_pwr`, `avg_pwr`, `inst_neg`, `pwr_rdy` and `avg_valid` are all zero. The shift is 0 and the window depth code is 0, which gives a one-sample window.
- R2: A sample accepted with `in_valid` high at clock edge k appears on `inst_pwr` after edge k+1 as floor(|in_cur| × in_volt / 2^shift). `pwr_rdy` is high for exactly that one cycle.
- R3: If the shifted product exceeds 65535, `inst_pwr` reads 65535 (0xFFFF) and does not wrap. Averages of clamped samples stay at 65535.
- R4: `in_cur` is two's complement. A negative code sets `inst_neg` to 1 and uses the code's magnitude, so -32768 counts as 32768. A zero or positive code clears `inst_neg`.
- R5: Current and voltage are sampled on the same edge as `in_valid`. Changes on `in_cur` or `in_volt` while `in_valid` is low leave `inst_pwr` and `inst_neg` unchanged and produce no `pwr_rdy`.
- R6: `cfg_shift` (0 to 31), loaded by `cfg_wr`, sets the right shift that is applied to the full-width product before the clamp.
- R7: `cfg_depth` selects the window: code 0 is 1 sample, code 1 is 4, code 2 is 16, code 3 is 64. When the last sample of a window arrives, `avg_pwr` takes floor(sum / N) of the window's `inst_pwr` values one cycle after that sample's `pwr_rdy`, and `avg_valid` pulses for one cycle.
- R8: Between window completions, `avg_pwr` holds its last value and `avg_valid` stays low.
- R9: A cycle with `cfg_wr` high clears `inst_pwr`, `avg_pwr`, `inst_neg` and the partial window, and it discards a sample captured but not yet published. After that, the next window counts only samples that arrive after the write.
- R10: With a window of one sample, every `pwr_rdy` is followed on the next cycle by `avg_valid`, with `avg_pwr` equal to that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration load strobe; also clears state |
| cfg_shift | input | 5 | Product right-shift amount |
| cfg_depth | input | 2 | Averaging window code (1/4/16/64 samples) |
| in_valid | input | 1 | New coherent current/voltage pair |
| in_cur | input | 16 | Signed current code |
| in_volt | input | 16 | Unsigned bus-voltage code |
| inst_pwr | output | 16 | Instantaneous power, clamped |
| inst_neg | output | 1 | Current direction of the latest sample |
| pwr_rdy | output | 1 | One-cycle pulse on a new instantaneous value |
| avg_pwr | output | 16 | Window-averaged power |
| avg_valid | output | 1 | One-cycle pulse on a new average |

## Verification
The hardest case to reach from the ports is a configuration write that lands while a sample has been captured but not yet published. To create it, the bench raises `in_valid` and asserts `cfg_wr` on the very next cycle, then confirms that no `pwr_rdy` ever appears and that both registers stay at zero. A second hard case is a clear that falls in the middle of a window. Here the bench feeds a partial window, writes the configuration, and then checks that the next average contains only the samples that follow the write. The 64-sample window is covered with a full run of distinct values, so a wrong divide shift or a wrong window count shows up in the result.

// File: rtl/pwr_pkg.sv
// Shared constants and types for the power product and averaging engine.
// Assumes the window depth code maps to 2^(LOG_STEP*code) samples.
package pwr_pkg;
    localparam int DEPTH_CODE_W = 2;
    localparam int LOG_STEP     = 2;
    localparam int MAX_LOG      = LOG_STEP * ((1 << DEPTH_CODE_W) - 1);

    typedef enum logic [DEPTH_CODE_W-1:0] {
        WIN_1  = 2'd0,
        WIN_4  = 2'd1,
        WIN_16 = 2'd2,
        WIN_64 = 2'd3
    } win_code_e;
endpackage

// File: rtl/pwr_capture.sv
// Input stage: registers a current/voltage pair on one shared strobe and
// splits the signed current into magnitude and direction.
// Assumes in_cur is two's complement; clr wins over a new sample.
module pwr_capture #(
    parameter int I_W = 16,
    parameter int V_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  in_valid,
    input  logic signed [I_W-1:0] in_cur,
    input  logic        [V_W-1:0] in_volt,
    output logic                  cap_vld,
    output logic        [I_W-1:0] cap_mag,
    output logic                  cap_neg,
    output logic        [V_W-1:0] cap_volt
);
    logic [I_W-1:0] mag_c;

    // Magnitude of the current code; the most negative code maps to 2^(I_W-1).
    always_comb begin
        mag_c = in_cur[I_W-1] ? (~in_cur + 1'b1) : in_cur;
    end

    // Capture the pair coherently and flag it for the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cap_vld  <= 1'b0;
            cap_mag  <= '0;
            cap_neg  <= 1'b0;
            cap_volt <= '0;
        end else begin
            cap_vld <= in_valid;
            if (in_valid) begin
                cap_mag  <= mag_c;
                cap_neg  <= in_cur[I_W-1];
                cap_volt <= in_volt;
            end
        end
    end

    p_pair_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !clr |=> cap_vld && cap_volt == $past(in_volt) && cap_neg == $past(in_cur[I_W-1]));
    p_idle_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !cap_vld);
endmodule

// File: rtl/pwr_scale.sv
// Multiplier stage: forms |I| x V at full width, shifts it to the power LSB
// and clamps to the register range, then publishes it with a ready pulse.
// Assumes the shift amount is stable while samples are in flight.
module pwr_scale #(
    parameter int I_W  = 16,
    parameter int V_W  = 16,
    parameter int P_W  = 16,
    parameter int SH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [SH_W-1:0] shift,
    input  logic            cap_vld,
    input  logic [I_W-1:0]  cap_mag,
    input  logic            cap_neg,
    input  logic [V_W-1:0]  cap_volt,
    output logic [P_W-1:0]  inst_pwr,
    output logic            inst_neg,
    output logic            inst_rdy
);
    localparam int PROD_W = I_W + V_W;

    logic [PROD_W-1:0] prod_c;
    logic [PROD_W-1:0] shifted_c;
    logic              ovf_c;
    logic [P_W-1:0]    next_c;

    // Full-width product followed by the programmable LSB shift.
    always_comb begin
        prod_c    = {{V_W{1'b0}}, cap_mag} * {{I_W{1'b0}}, cap_volt};
        shifted_c = prod_c >> shift;
    end

    // Overflow detection only exists when the product is wider than the register.
    generate
        if (PROD_W > P_W) begin : g_clamp
            assign ovf_c = |shifted_c[PROD_W-1:P_W];
        end else begin : g_fit
            assign ovf_c = 1'b0;
        end
    endgenerate

    // Saturate instead of wrapping.
    always_comb begin
        next_c = ovf_c ? {P_W{1'b1}} : P_W'(shifted_c);
    end

    // Publish the instantaneous register and its ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            inst_pwr <= '0;
            inst_neg <= 1'b0;
            inst_rdy <= 1'b0;
        end else begin
            inst_rdy <= cap_vld;
            if (cap_vld) begin
                inst_pwr <= next_c;
                inst_neg <= cap_neg;
            end
        end
    end

    p_inst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld && !clr |=> $stable(inst_pwr) && $stable(inst_neg) && !inst_rdy);
    p_inst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> inst_pwr == '0 && !inst_neg && !inst_rdy);
    p_zero_in_zero_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld && !clr && (cap_mag == '0 || cap_volt == '0) |=> inst_pwr == '0);
endmodule

// File: rtl/pwr_block_avg.sv
// Block averager: sums a window of 2^(LOG_STEP*code) samples and divides by
// shifting when the window closes. Assumes samples never exceed the P_W range,
// so the accumulator needs only MAX_LOG extra bits.
module pwr_block_avg
    import pwr_pkg::*;
#(
    parameter int P_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [DEPTH_CODE_W-1:0] depth,
    input  logic                    smp_vld,
    input  logic [P_W-1:0]          smp,
    output logic [P_W-1:0]          avg_pwr,
    output logic                    avg_valid
);
    localparam int ACC_W = P_W + MAX_LOG;
    localparam int CNT_W = (MAX_LOG > 0) ? MAX_LOG : 1;

    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] sum_c;
    logic [CNT_W-1:0] last_c;
    int unsigned      log_c;

    // Window length and running sum including the incoming sample.
    always_comb begin
        log_c  = LOG_STEP * int'(depth);
        last_c = CNT_W'((1 << log_c) - 1);
        sum_c  = acc_q + ACC_W'(smp);
    end

    // Accumulate, and on the window's last sample publish and restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q     <= '0;
            cnt_q     <= '0;
            avg_pwr   <= '0;
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= 1'b0;
            if (smp_vld) begin
                if (cnt_q == last_c) begin
                    avg_pwr   <= P_W'(sum_c >> log_c);
                    avg_valid <= 1'b1;
                    acc_q     <= '0;
                    cnt_q     <= '0;
                end else begin
                    acc_q <= sum_c;
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    p_window_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_c || $past(clr) || $past(depth) != depth);
    p_avg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld && !clr |=> !avg_valid && $stable(avg_pwr));
    p_avg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> avg_pwr == '0 && !avg_valid && cnt_q == '0);
    p_single_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld && !clr && depth == WIN_1 |=> avg_valid && avg_pwr == $past(smp));
endmodule

// File: rtl/pwr_avg_engine.sv
// Top: holds the configuration, and chains capture -> product/scale/clamp ->
// block average. A configuration write reloads shift and depth and clears
// all results, the partial window and any sample in flight.
module pwr_avg_engine
    import pwr_pkg::*;
#(
    parameter int I_W  = 16,
    parameter int V_W  = 16,
    parameter int P_W  = 16,
    parameter int SH_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [SH_W-1:0]         cfg_shift,
    input  logic [DEPTH_CODE_W-1:0] cfg_depth,
    input  logic                    in_valid,
    input  logic signed [I_W-1:0]   in_cur,
    input  logic [V_W-1:0]          in_volt,
    output logic [P_W-1:0]          inst_pwr,
    output logic                    inst_neg,
    output logic                    pwr_rdy,
    output logic [P_W-1:0]          avg_pwr,
    output logic                    avg_valid
);
    logic [SH_W-1:0]         shift_q;
    logic [DEPTH_CODE_W-1:0] depth_q;
    logic                    cap_vld;
    logic [I_W-1:0]          cap_mag;
    logic                    cap_neg;
    logic [V_W-1:0]          cap_volt;

    // Configuration registers, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            depth_q <= WIN_1;
        end else if (cfg_wr) begin
            shift_q <= cfg_shift;
            depth_q <= cfg_depth;
        end
    end

    pwr_capture #(.I_W(I_W), .V_W(V_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr),
        .in_valid(in_valid), .in_cur(in_cur), .in_volt(in_volt),
        .cap_vld(cap_vld), .cap_mag(cap_mag), .cap_neg(cap_neg), .cap_volt(cap_volt)
    );

    pwr_scale #(.I_W(I_W), .V_W(V_W), .P_W(P_W), .SH_W(SH_W)) u_scale (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .shift(shift_q),
        .cap_vld(cap_vld), .cap_mag(cap_mag), .cap_neg(cap_neg), .cap_volt(cap_volt),
        .inst_pwr(inst_pwr), .inst_neg(inst_neg), .inst_rdy(pwr_rdy)
    );

    pwr_block_avg #(.P_W(P_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .depth(depth_q),
        .smp_vld(pwr_rdy), .smp(inst_pwr),
        .avg_pwr(avg_pwr), .avg_valid(avg_valid)
    );

    p_rdy_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_wr ##1 !cfg_wr |=> pwr_rdy);
    p_avg_after_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        avg_valid |-> $past(pwr_rdy));
endmodule

// File: tb/pwr_avg_engine_tb.sv
// Directed bench for the power product and averaging engine.
module pwr_avg_engine_tb;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_wr;
    logic [4:0]         cfg_shift;
    logic [1:0]         cfg_depth;
    logic               in_valid;
    logic signed [15:0] in_cur;
    logic [15:0]        in_volt;
    logic [15:0]        inst_pwr;
    logic               inst_neg;
    logic               pwr_rdy;
    logic [15:0]        avg_pwr;
    logic               avg_valid;

    int checks = 0;
    int errors = 0;
    int cur_shift = 0;

    always #2 clk = ~clk;

    pwr_avg_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_shift(cfg_shift),
        .cfg_depth(cfg_depth), .in_valid(in_valid), .in_cur(in_cur), .in_volt(in_volt),
        .inst_pwr(inst_pwr), .inst_neg(inst_neg), .pwr_rdy(pwr_rdy),
        .avg_pwr(avg_pwr), .avg_valid(avg_valid)
    );

    function automatic longint exp_pwr(input longint c, input longint v, input int sh);
        longint m = (c < 0) ? -c : c;
        longint p = (m * v) >>> sh;
        return (p > 65535) ? 65535 : p;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_cfg(input int sh, input int dc, input string req);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_shift = 5'(sh); cfg_depth = 2'(dc);
        @(negedge clk);
        cfg_wr = 1'b0;
        cur_shift = sh;
        check({req, " inst cleared"}, inst_pwr, 0);
        check({req, " avg cleared"}, avg_pwr, 0);
        check({req, " sign cleared"}, inst_neg, 0);
    endtask

    // Send one sample; check the instantaneous result two edges later.
    task automatic send(input longint c, input longint v, input string req, output longint got);
        @(negedge clk);
        in_valid = 1'b1; in_cur = 16'(c); in_volt = 16'(v);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " rdy"}, pwr_rdy, 1);
        check({req, " inst"}, inst_pwr, exp_pwr(c, v, cur_shift));
        check({req, " sign"}, inst_neg, (c < 0) ? 1 : 0);
        got = inst_pwr;
    endtask

    task automatic check_avg(input string req, input longint exp);
        @(negedge clk);
        check({req, " avg_valid"}, avg_valid, 1);
        check({req, " avg"}, avg_pwr, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; cfg_wr = 0; cfg_shift = 0; cfg_depth = 0;
        in_valid = 0; in_cur = 0; in_volt = 0;
        repeat (3) @(negedge clk);
        check("R1 inst", inst_pwr, 0);
        check("R1 avg", avg_pwr, 0);
        check("R1 neg", inst_neg, 0);
        check("R1 rdy", pwr_rdy, 0);
        check("R1 avg_valid", avg_valid, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_basic;
        longint g;
        send(100, 300, "R2 basic default shift", g);
        check_avg("R1 default one-sample window", 30000);
        send(1000, 2000, "R3 clamp", g);
        send(32767, 65535, "R3 clamp max", g);
        send(-100, 300, "R4 negative", g);
        send(-32768, 1, "R4 most negative", g);
        send(0, 500, "R4 zero current", g);
    endtask

    task automatic t_coherent;
        longint g;
        send(100, 300, "R5 setup", g);
        @(negedge clk);
        in_cur = -16'sd5000; in_volt = 16'd9;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R5 no rdy", pwr_rdy, 0);
            check("R5 inst held", inst_pwr, 30000);
            check("R5 sign held", inst_neg, 0);
        end
    endtask

    task automatic t_shift;
        longint g;
        do_cfg(8, 0, "R9 cfg shift8");
        send(1000, 5000, "R6 shift 8", g);
        send(20000, 30000, "R6 shift 8 clamp", g);
        do_cfg(31, 0, "R9 cfg shift31");
        send(-32768, 65535, "R6 shift 31", g);
    endtask

    task automatic t_depth1;
        longint g;
        do_cfg(0, 0, "R9 cfg depth1");
        for (int k = 0; k < 3; k++) begin
            send(50 + 7 * k, 11, "R10 sample", g);
            check_avg("R10 equals sample", g);
        end
    endtask

    task automatic t_depth4;
        longint g;
        longint vals[4] = '{10, 20, 30, 41};
        do_cfg(0, 1, "R9 cfg depth4");
        for (int k = 0; k < 4; k++) send(vals[k], 1, "R7 w4 sample", g);
        check_avg("R7 window of 4", 25);
        send(900, 1, "R8 partial 1", g);
        @(negedge clk);
        check("R8 no avg_valid", avg_valid, 0);
        check("R8 avg held", avg_pwr, 25);
        send(-800, 1, "R8 partial 2", g);
        @(negedge clk);
        check("R8 avg still held", avg_pwr, 25);
        do_cfg(0, 1, "R9 mid-window clear");
        for (int k = 0; k < 4; k++) send(4 + k, 1, "R9 fresh window", g);
        check_avg("R9 only post-clear samples", 5);
        for (int k = 0; k < 4; k++) send(3000, 3000, "R3 clamp window", g);
        check_avg("R3 avg of clamped", 65535);
    endtask

    task automatic t_depth16_64;
        longint g;
        longint sum;
        do_cfg(0, 2, "R9 cfg depth16");
        sum = 0;
        for (int k = 0; k < 16; k++) begin
            send(k * 100 + 7, 3, "R7 w16 sample", g);
            sum += g;
        end
        check_avg("R7 window of 16", sum >> 4);
        do_cfg(0, 3, "R9 cfg depth64");
        sum = 0;
        for (int k = 0; k < 64; k++) begin
            send(-(1000 + k), 50 + (k % 3), "R7 w64 sample", g);
            sum += g;
        end
        check_avg("R7 window of 64", sum >> 6);
    endtask

    task automatic t_inflight;
        do_cfg(0, 0, "R9 cfg pre-inflight");
        @(negedge clk);
        in_valid = 1'b1; in_cur = 16'sd200; in_volt = 16'd100;
        @(negedge clk);
        in_valid = 1'b0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R9 in-flight dropped rdy", pwr_rdy, 0);
        check("R9 in-flight inst", inst_pwr, 0);
        @(negedge clk);
        check("R9 in-flight no late rdy", pwr_rdy, 0);
        check("R9 in-flight no avg", avg_valid, 0);
        check("R9 in-flight avg zero", avg_pwr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_coherent();
        t_shift();
        t_depth1();
        t_depth4();
        t_depth16_64();
        t_inflight();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule